// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flagged Receive Queue

This block turns a 16x-oversampled asynchronous serial line into characters of five to nine bits. A falling level on the line is checked again half a bit later. If the line is still low, the block takes it as a start bit. It then samples each data bit near its centre, least significant bit first. An optional parity bit follows the data, and then the first stop bit. When that stop bit is sampled, the finished character goes into a small queue together with its own status: the ninth data bit, a framing error, a parity error and an overrun mark.

The queue head is presented on the read side. Software-style logic reads the ninth bit and the error flags first, then reads the low byte with a one-cycle pop strobe, which moves the queue on. A receive-complete output shows that unread characters are present. An interrupt output follows it when the interrupt enable is set. Dropping the receive enable empties the queue and puts the receiver back into its idle state.

The receiver state machine has five states. IDLE waits for a low line on an oversample tick. START counts to mid-bit: it returns to IDLE on a high sample (glitch) or moves to DATA on a low one. DATA samples one bit per 16 ticks and moves to PARITY when parity is enabled, or otherwise to STOP after the last bit. PARITY samples one bit and moves to STOP. STOP samples the first stop bit, hands over the character and returns to IDLE. Clearing the enable forces IDLE from any state.

Top module: `uart_rx_flagfifo`

## Requirements
- R1: A low line seen on an oversample tick in IDLE is checked again 8 ticks later. If the line is high at that point, the character is abandoned and nothing is stored.
- R2: Data bits are taken least significant first. The count comes from `size_code`: 0,1,2,3 give 5,6,7,8 bits, 7 gives 9 bits, and any other code gives 8 bits. Unused upper bits read as 0, and bit 8 appears on `rd_bit8`.
- R3: With `par_en` high, one parity bit follows the last data bit. The expected value is the XOR of the data bits, inverted when `par_odd` is high. A mismatch sets `rd_perr` for that character only.
- R4: `rd_ferr` is set for a character whose first stop bit samples low. Nothing after the first stop bit is checked, so a short low pulse after it leaves the character error-free.
- R5: Each queue entry keeps its own data, ninth bit and flags. The head is shown on the read outputs, and a `rd_pop` pulse while not empty moves to the next entry.
- R6: The queue holds 2 entries. A character finishing while the queue is full is dropped, and `rd_ovr` is set on the most recently stored entry.
- R7: `rxc` is high exactly while the queue holds at least one unread entry.
- R8: `irq` is high exactly when `rxc` and `rxc_ie` are both high.
- R9: While `rx_en` is low, the queue is empty, `rxc` is low, and line activity stores nothing.
- R10: After reset, `rxc`, `irq` and all read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low flushes and idles |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| size_code | input | 3 | Character length code |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when high, even when low |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| rd_pop | input | 1 | Read low byte; pops the head entry |
| rd_byte | output | 8 | Head entry low data byte |
| rd_bit8 | output | 1 | Head entry ninth data bit |
| rd_ferr | output | 1 | Head entry framing error |
| rd_ovr | output | 1 | Head entry overrun mark |
| rd_perr | output | 1 | Head entry parity error |
| rxc | output | 1 | Unread data present |
| irq | output | 1 | Receive interrupt |

## Verification
The assertions assume that `os_tick` lasts one cycle and comes at least a few clocks apart. They also assume that `rxd` holds each bit long enough for the mid-bit samples to land inside it, and that the configuration inputs stay still while a character is being received. The stimulus generates the tick every fourth clock and holds each line level for 64 clocks. It changes the configuration and enable only between characters, and it shapes the low stop bit and the post-stop glitch so that the follow-on start check falls on a high line.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic       ovr;
        logic       perr;
        logic       ferr;
        logic [8:0] data;
    } rx_entry_t;

    function automatic logic [3:0] size_to_bits(input logic [2:0] code);
        logic [3:0] n;
        case (code)
            3'd0:    n = 4'd5;
            3'd1:    n = 4'd6;
            3'd2:    n = 4'd7;
            3'd3:    n = 4'd8;
            3'd7:    n = 4'd9;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      tick,
    input  logic      rxd_s,
    input  logic [2:0] size_code,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      frame_valid,
    output rx_entry_t frame
);
    localparam int CW = $clog2(OS);
    localparam logic [CW-1:0] MID  = CW'(OS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OS - 1);

    rx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [3:0]    bit_idx_q;
    logic [8:0]    shreg_q;
    logic          par_bit_q;
    logic [3:0]    nbits;

    assign nbits = size_to_bits(size_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick && !rxd_s) state_d = ST_START;
            ST_START:  if (tick && cnt_q == MID) state_d = rxd_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (tick && cnt_q == LAST && bit_idx_q == nbits - 4'd1)
                           state_d = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (tick && cnt_q == LAST) state_d = ST_STOP;
            ST_STOP:   if (tick && cnt_q == LAST) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (!enable) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            bit_idx_q   <= '0;
            shreg_q     <= '0;
            par_bit_q   <= 1'b0;
            frame_valid <= 1'b0;
            frame       <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (!enable || state_q == ST_IDLE) begin
                cnt_q     <= '0;
                bit_idx_q <= '0;
                shreg_q   <= '0;
                par_bit_q <= 1'b0;
            end else if (tick) begin
                unique case (state_q)
                    ST_START: cnt_q <= (cnt_q == MID) ? '0 : cnt_q + 1'b1;
                    ST_DATA: begin
                        if (cnt_q == LAST) begin
                            shreg_q[bit_idx_q] <= rxd_s;
                            bit_idx_q          <= bit_idx_q + 4'd1;
                        end
                        cnt_q <= cnt_q + 1'b1;
                    end
                    ST_PARITY: begin
                        if (cnt_q == LAST) par_bit_q <= rxd_s;
                        cnt_q <= cnt_q + 1'b1;
                    end
                    ST_STOP: begin
                        if (cnt_q == LAST) begin
                            frame_valid <= 1'b1;
                            frame.data  <= shreg_q;
                            frame.ferr  <= !rxd_s;
                            frame.perr  <= par_en && (par_bit_q != ((^shreg_q) ^ par_odd));
                            frame.ovr   <= 1'b0;
                        end
                        cnt_q <= cnt_q + 1'b1;
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    // R1
    start_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state_q == ST_START && cnt_q == MID && rxd_s) |=> state_q == ST_IDLE);

    // R4
    stop_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> state_q == ST_IDLE);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      not_empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    rx_entry_t     mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q, newest;
    logic [CW-1:0] count_q;
    logic          do_pop, blocked, do_push;

    assign do_pop  = pop && count_q != '0;
    assign blocked = (count_q == CFULL) && !do_pop;
    assign do_push = push && !blocked;
    assign newest  = (wr_q == '0) ? PLAST : wr_q - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (flush) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (push && blocked) mem_q[newest].ovr <= 1'b1;
            if (do_push) begin
                mem_q[wr_q] <= push_entry;
                wr_q        <= (wr_q == PLAST) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) rd_q <= (rd_q == PLAST) ? '0 : rd_q + 1'b1;
            count_q <= count_q + CW'(do_push) - CW'(do_pop);
        end
    end

    assign not_empty = count_q != '0;
    assign head      = not_empty ? mem_q[rd_q] : '0;

    // R6
    overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && push && count_q == CFULL && !pop) |=> count_q == CFULL);

    // R5
    pop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && pop && !push && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !not_empty);

endmodule

// File: rtl/uart_rx_flagfifo.sv
module uart_rx_flagfifo
    import uart_rx_pkg::*;
#(
    parameter int OS    = 16,
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [2:0] size_code,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rxc_ie,
    input  logic       rd_pop,
    output logic [7:0] rd_byte,
    output logic       rd_bit8,
    output logic       rd_ferr,
    output logic       rd_ovr,
    output logic       rd_perr,
    output logic       rxc,
    output logic       irq
);
    logic [1:0] sync_q;
    logic       frame_valid;
    rx_entry_t  frame, head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    uart_rx_fsm #(.OS(OS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (rx_en),
        .tick        (os_tick),
        .rxd_s       (sync_q[1]),
        .size_code   (size_code),
        .par_en      (par_en),
        .par_odd     (par_odd),
        .frame_valid (frame_valid),
        .frame       (frame)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (!rx_en),
        .push       (frame_valid && rx_en),
        .push_entry (frame),
        .pop        (rd_pop),
        .head       (head),
        .not_empty  (rxc)
    );

    assign rd_byte = head.data[7:0];
    assign rd_bit8 = head.data[8];
    assign rd_ferr = head.ferr;
    assign rd_perr = head.perr;
    assign rd_ovr  = head.ovr;
    assign irq     = rxc && rxc_ie;

    // R8
    irq_needs_rxc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rxc);

    // R7
    rxc_clear_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rxc);

endmodule

// File: tb/uart_rx_flagfifo_tb.sv
module uart_rx_flagfifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [2:0] size_code = 3'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rxc_ie = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_byte;
    logic       rd_bit8, rd_ferr, rd_ovr, rd_perr, rxc, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    logic [11:0] model_q[$];   // [8:0] data, [9] ferr, [10] perr, [11] ovr
    logic [1:0]  tick_cnt = '0;

    localparam int BIT_CLK = 64;

    uart_rx_flagfifo u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
        .size_code(size_code), .par_en(par_en), .par_odd(par_odd), .rxc_ie(rxc_ie),
        .rd_pop(rd_pop), .rd_byte(rd_byte), .rd_bit8(rd_bit8), .rd_ferr(rd_ferr),
        .rd_ovr(rd_ovr), .rd_perr(rd_perr), .rxc(rxc), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        tick_cnt <= tick_cnt + 2'd1;
        os_tick  <= (tick_cnt == 2'd3);
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [11:0] head_exp();
        if (model_q.size() == 0) return '0;
        return model_q[0];
    endfunction

    // per-clock comparison against the behavioural queue
    always @(posedge clk) begin
        if (cmp_on && rst_n) begin
            #1;
            check("R7 rxc", rxc, model_q.size() != 0);
            check("R8 irq", irq, (model_q.size() != 0) && rxc_ie);
            check("R5 head", {rd_ovr, rd_perr, rd_ferr, rd_bit8, rd_byte}, head_exp());
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    // stop_mode: 0 good stop, 1 low stop, 2 good stop then short low pulse
    task automatic send(input logic [8:0] d, input int nbits, input bit bad_par,
                        input int stop_mode, input bit stored);
        logic [8:0] dm;
        logic       p;
        dm = '0;
        for (int i = 0; i < nbits; i++) dm[i] = d[i];
        p = (^dm) ^ par_odd ^ bad_par;
        cmp_on = 1'b0;
        @(negedge clk);
        hold(1'b0, BIT_CLK);
        for (int i = 0; i < nbits; i++) hold(dm[i], BIT_CLK);
        if (par_en) hold(p, BIT_CLK);
        if (stop_mode == 1) begin
            hold(1'b0, 48);
            hold(1'b1, BIT_CLK * 2);
        end else begin
            hold(1'b1, BIT_CLK);
            if (stop_mode == 2) hold(1'b0, 12);
            hold(1'b1, BIT_CLK * 2);
        end
        if (stored) begin
            if (model_q.size() < 2) model_q.push_back({1'b0, bad_par && par_en, stop_mode == 1, dm});
            else model_q[model_q.size() - 1][11] = 1'b1;
        end
        cmp_on = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_check(input string tag, input logic [11:0] exp);
        @(negedge clk);
        check(tag, {rd_ovr, rd_perr, rd_ferr, rd_bit8, rd_byte}, exp);
        rd_pop = 1'b1;
        if (model_q.size() != 0) void'(model_q.pop_front());
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 rxc", rxc, 1'b0);
        check("R10 irq", irq, 1'b0);
        check("R10 read outputs", {rd_ovr, rd_perr, rd_ferr, rd_bit8, rd_byte}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        rx_en = 1'b1;
        rxc_ie = 1'b1;
        cmp_on = 1'b1;
        repeat (8) @(negedge clk);

        // R1 glitch on the line
        cmp_on = 1'b0;
        hold(1'b0, 12);
        hold(1'b1, BIT_CLK * 3);
        cmp_on = 1'b1;
        check("R1 glitch stores nothing", rxc, 1'b0);

        // R2 8-bit character
        size_code = 3'd3;
        send(9'h0A5, 8, 1'b0, 0, 1'b1);
        check("R8 irq with entry", irq, 1'b1);
        rxc_ie = 1'b0;
        @(negedge clk);
        check("R8 irq masked", irq, 1'b0);
        rxc_ie = 1'b1;
        read_check("R2 eight bits", 12'h0A5);

        // R2 5-bit and 7-bit characters, default code
        size_code = 3'd0;
        send(9'h1FF, 5, 1'b0, 0, 1'b1);
        read_check("R2 five bits", 12'h01F);
        size_code = 3'd2;
        send(9'h155, 7, 1'b0, 0, 1'b1);
        read_check("R2 seven bits", 12'h055);
        size_code = 3'd5;
        send(9'h13C, 8, 1'b0, 0, 1'b1);
        read_check("R2 default code eight bits", 12'h03C);

        // R2 R3 9-bit with even parity, good then bad
        size_code = 3'd7;
        par_en = 1'b1;
        par_odd = 1'b0;
        send(9'h16B, 9, 1'b0, 0, 1'b1);
        send(9'h0F0, 9, 1'b1, 0, 1'b1);
        read_check("R3 good parity ninth bit", 12'h16B);
        read_check("R3 bad parity flagged", 12'h4F0);
        // R3 odd parity
        size_code = 3'd3;
        par_odd = 1'b1;
        send(9'h037, 8, 1'b0, 0, 1'b1);
        read_check("R3 odd parity good", 12'h037);
        par_en = 1'b0;

        // R4 framing error and second stop ignored
        send(9'h0C3, 8, 1'b0, 1, 1'b1);
        read_check("R4 low stop flags ferr", 12'h2C3);
        send(9'h081, 8, 1'b0, 2, 1'b1);
        read_check("R4 only first stop checked", 12'h081);
        check("R7 empty after reads", rxc, 1'b0);

        // R6 overrun on full queue
        send(9'h011, 8, 1'b0, 0, 1'b1);
        send(9'h022, 8, 1'b0, 0, 1'b1);
        send(9'h033, 8, 1'b0, 0, 1'b1);
        read_check("R6 oldest intact", 12'h011);
        read_check("R6 newest marked overrun", 12'h822);
        check("R6 dropped data absent", rxc, 1'b0);

        // R9 flush and disabled line
        send(9'h044, 8, 1'b0, 0, 1'b1);
        @(negedge clk);
        rx_en = 1'b0;
        model_q.delete();
        @(negedge clk);
        check("R9 flush clears rxc", rxc, 1'b0);
        send(9'h055, 8, 1'b0, 0, 1'b0);
        check("R9 disabled stores nothing", rxc, 1'b0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        send(9'h066, 8, 1'b0, 0, 1'b1);
        read_check("R9 receive after re-enable", 12'h066);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule